// File: doc/BRIEF.md
# Register-Indirect Effective Address Unit

This block holds the sixteen 16-bit working registers of a small 16-bit datapath and turns a register-indirect operand request into an effective data address. A request names a base register, an addressing mode, a byte or word operand size, and, depending on the mode, a second register or a signed literal. The block produces the address and the updated base value for the self-modifying modes, and writes that value back into its own register file.

The block also enforces two operand rules. A word access must land on an even address, and a register may only serve as a pointer once it has been written at least once since reset. If either rule is broken, the block raises a one-cycle trap with a cause code and changes no register state. A separate write port loads the registers, and a read port shows any register's current value.

Top module: `ria_agu`

## Requirements
- R1: After reset every register reads 0 and is marked unwritten, and `trap`, `wb_en` and `ea_valid` are low.
- R2: Mode code 0 (plain) and the reserved code 7 give an address equal to the base register, with no write-back (`wb_en` low and the register unchanged).
- R3: The modify step is 1 when `req_word` is 0 (byte) and 2 when `req_word` is 1 (word).
- R4: Mode 1 (post-increment) and mode 2 (post-decrement) give the unmodified base as the address and write base plus or minus the step back to the base register, with `wb_en` high and `base_new` carrying the written value.
- R5: Mode 3 (pre-increment) and mode 4 (pre-decrement) give the modified base as the address and write that same value back to the base register.
- R6: Mode 5 gives an address equal to the base register plus the register named by `req_index`, with no write-back.
- R7: Mode 6 gives an address equal to the base register plus `req_lit` read as a 10-bit two's-complement value and sign-extended, with no write-back.
- R8: All address and pointer arithmetic wraps modulo 2^16.
- R9: A word access whose effective address is odd raises `trap` with `trap_cause` bit 0 set.
- R10: A request whose base register is unwritten since reset raises `trap` with `trap_cause` bit 1 set. In mode 5 an unwritten index register does the same. A register becomes written through the write port.
- R11: When a trap is raised, `ea_valid` and `wb_en` are low, no register changes, and `trap` is high for exactly the one cycle that belongs to that request.
- R12: Results appear on the outputs after the clock edge that samples `req_valid`, and the register update takes effect at that same edge. `ea_valid`, `wb_en` and `trap` are low in every cycle that follows an edge with no request.
- R13: When the write port and a write-back target the same register at the same edge, the write-port value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register to write |
| wr_data | input | 16 | Value to write |
| rd_idx | input | 4 | Register to observe |
| rd_data | output | 16 | Current value of register `rd_idx` |
| req_valid | input | 1 | Address request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_base | input | 4 | Base register index |
| req_index | input | 4 | Index register for mode 5 |
| req_lit | input | 10 | Signed literal for mode 6 |
| req_word | input | 1 | 1 = word operand, 0 = byte operand |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | Address is valid (request without trap) |
| base_new | output | 16 | Modified base value |
| wb_en | output | 1 | Base register was written back |
| trap | output | 1 | Address-error pulse |
| trap_cause | output | 2 | Bit 0 misaligned word, bit 1 unwritten pointer |

## Verification
Every result of a request is due one edge after the request is sampled. The address, `base_new`, `wb_en`, `ea_valid`, `trap` and `trap_cause` are all registered, and the register-file update lands on that same edge. The bench drives a request on a falling edge and withdraws it on the next falling edge. It then reads the outputs, and the base register through the combinational read port, half a period after the sampling edge. One more falling edge later it confirms that the trap and valid flags have dropped again.

// File: rtl/ria_pkg.sv
// Shared types for the register-indirect address unit.
// Assumes: mode codes are fixed by the instruction encoding feeding req_mode.
package ria_pkg;

    typedef enum logic [2:0] {
        AM_PLAIN    = 3'd0,
        AM_POST_INC = 3'd1,
        AM_POST_DEC = 3'd2,
        AM_PRE_INC  = 3'd3,
        AM_PRE_DEC  = 3'd4,
        AM_REG_REG  = 3'd5,
        AM_REG_LIT  = 3'd6,
        AM_RSVD     = 3'd7
    } amode_e;

    localparam int CAUSE_ALIGN  = 0;
    localparam int CAUSE_UNINIT = 1;
    localparam int CAUSE_W      = 2;

endpackage

// File: rtl/ria_regfile.sv
// Working register file with a per-register "written since reset" flag.
// One external write port and one write-back port; the external port
// wins on a same-register collision. Three combinational read ports.
// Assumes: synchronous active-low reset clears values and flags.
module ria_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_we,
    input  logic [IDXW-1:0] ext_idx,
    input  logic [DW-1:0]   ext_data,
    input  logic            wb_we,
    input  logic [IDXW-1:0] wb_idx,
    input  logic [DW-1:0]   wb_data,
    input  logic [IDXW-1:0] ra_idx,
    output logic [DW-1:0]   ra_data,
    output logic            ra_init,
    input  logic [IDXW-1:0] rb_idx,
    output logic [DW-1:0]   rb_data,
    output logic            rb_init,
    input  logic [IDXW-1:0] rc_idx,
    output logic [DW-1:0]   rc_data
);

    logic [DW-1:0] regs_q    [NREG];
    logic          written_q [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            // Update one register: external write first, then write-back.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[i]    <= '0;
                    written_q[i] <= 1'b0;
                end else if (ext_we && ext_idx == IDXW'(i)) begin
                    regs_q[i]    <= ext_data;
                    written_q[i] <= 1'b1;
                end else if (wb_we && wb_idx == IDXW'(i)) begin
                    regs_q[i]    <= wb_data;
                    written_q[i] <= 1'b1;
                end
            end

            // Once marked written, a register stays written until reset.
            p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $past(written_q[i]) |-> written_q[i]);
        end
    endgenerate

    // Write-back only ever targets a register already in use as a pointer.
    p_wb_on_written_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> written_q[wb_idx]);

    // Read ports.
    always_comb begin
        ra_data = regs_q[ra_idx];
        ra_init = written_q[ra_idx];
        rb_data = regs_q[rb_idx];
        rb_init = written_q[rb_idx];
        rc_data = regs_q[rc_idx];
    end

endmodule

// File: rtl/ria_addr_calc.sv
// Combinational effective-address and base-modify arithmetic.
// Step is 1 for bytes and 2 for words; the literal is sign-extended
// from LITW bits; everything wraps modulo 2^DW.
module ria_addr_calc
    import ria_pkg::*;
#(
    parameter int DW   = 16,
    parameter int LITW = 10
) (
    input  amode_e          mode,
    input  logic            word,
    input  logic [DW-1:0]   base_val,
    input  logic [DW-1:0]   idx_val,
    input  logic [LITW-1:0] lit,
    output logic [DW-1:0]   ea,
    output logic [DW-1:0]   new_base,
    output logic            modifies
);

    localparam int EXTW = DW - LITW;

    logic [DW-1:0] step;
    logic [DW-1:0] lit_ext;
    logic [DW-1:0] inc_val;
    logic [DW-1:0] dec_val;

    // Operand-size step, sign-extended literal and both modified bases.
    always_comb begin
        step    = word ? DW'(2) : DW'(1);
        lit_ext = {{EXTW{lit[LITW-1]}}, lit};
        inc_val = base_val + step;
        dec_val = base_val - step;
    end

    // Select address and write-back value by mode.
    always_comb begin
        ea       = base_val;
        new_base = base_val;
        modifies = 1'b0;
        unique case (mode)
            AM_POST_INC: begin new_base = inc_val; modifies = 1'b1; end
            AM_POST_DEC: begin new_base = dec_val; modifies = 1'b1; end
            AM_PRE_INC:  begin new_base = inc_val; ea = inc_val; modifies = 1'b1; end
            AM_PRE_DEC:  begin new_base = dec_val; ea = dec_val; modifies = 1'b1; end
            AM_REG_REG:  ea = base_val + idx_val;
            AM_REG_LIT:  ea = base_val + lit_ext;
            default:     ea = base_val;
        endcase
    end

endmodule

// File: rtl/ria_trap_check.sv
// Combinational address-error detection: odd word address and
// indirection through an unwritten base (or index, in mode 5) register.
module ria_trap_check
    import ria_pkg::*;
#(
    parameter int DW = 16
) (
    input  amode_e             mode,
    input  logic               word,
    input  logic [DW-1:0]      ea,
    input  logic               base_init,
    input  logic               idx_init,
    output logic [CAUSE_W-1:0] cause
);

    // Build the cause vector; any set bit is a trap.
    always_comb begin
        cause               = '0;
        cause[CAUSE_ALIGN]  = word & ea[0];
        cause[CAUSE_UNINIT] = !base_init || (mode == AM_REG_REG && !idx_init);
    end

endmodule

// File: rtl/ria_agu.sv
// Register-indirect address unit: register file, address arithmetic,
// trap detection and a single output register stage. A request sampled
// at an edge updates outputs and the base register at that same edge;
// a trap suppresses write-back and pulses for one cycle.
module ria_agu
    import ria_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int LITW = 10,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [IDXW-1:0]    rd_idx,
    output logic [DW-1:0]      rd_data,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [IDXW-1:0]    req_base,
    input  logic [IDXW-1:0]    req_index,
    input  logic [LITW-1:0]    req_lit,
    input  logic               req_word,
    output logic [DW-1:0]      ea,
    output logic               ea_valid,
    output logic [DW-1:0]      base_new,
    output logic               wb_en,
    output logic               trap,
    output logic [CAUSE_W-1:0] trap_cause
);

    amode_e             mode;
    logic [DW-1:0]      base_val;
    logic [DW-1:0]      idx_val;
    logic               base_init;
    logic               idx_init;
    logic [DW-1:0]      ea_c;
    logic [DW-1:0]      new_base_c;
    logic               modifies_c;
    logic [CAUSE_W-1:0] cause_c;
    logic               fault_c;
    logic               wb_we_c;

    logic [DW-1:0]      ea_q;
    logic [DW-1:0]      base_new_q;
    logic               valid_q;
    logic               wb_q;
    logic               trap_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               word_q;

    // Decode mode and form the write-back strobe.
    always_comb begin
        mode    = amode_e'(req_mode);
        fault_c = |cause_c;
        wb_we_c = req_valid && modifies_c && !fault_c;
    end

    ria_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_we   (wr_en),
        .ext_idx  (wr_idx),
        .ext_data (wr_data),
        .wb_we    (wb_we_c),
        .wb_idx   (req_base),
        .wb_data  (new_base_c),
        .ra_idx   (req_base),
        .ra_data  (base_val),
        .ra_init  (base_init),
        .rb_idx   (req_index),
        .rb_data  (idx_val),
        .rb_init  (idx_init),
        .rc_idx   (rd_idx),
        .rc_data  (rd_data)
    );

    ria_addr_calc #(.DW(DW), .LITW(LITW)) u_calc (
        .mode     (mode),
        .word     (req_word),
        .base_val (base_val),
        .idx_val  (idx_val),
        .lit      (req_lit),
        .ea       (ea_c),
        .new_base (new_base_c),
        .modifies (modifies_c)
    );

    ria_trap_check #(.DW(DW)) u_trap (
        .mode      (mode),
        .word      (req_word),
        .ea        (ea_c),
        .base_init (base_init),
        .idx_init  (idx_init),
        .cause     (cause_c)
    );

    // Output register stage; flags are cleared in idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q       <= '0;
            base_new_q <= '0;
            valid_q    <= 1'b0;
            wb_q       <= 1'b0;
            trap_q     <= 1'b0;
            cause_q    <= '0;
            word_q     <= 1'b0;
        end else begin
            valid_q <= req_valid && !fault_c;
            wb_q    <= wb_we_c;
            trap_q  <= req_valid && fault_c;
            cause_q <= req_valid ? cause_c : '0;
            if (req_valid) begin
                ea_q       <= ea_c;
                base_new_q <= new_base_c;
                word_q     <= req_word;
            end
        end
    end

    // Drive ports.
    always_comb begin
        ea         = ea_q;
        base_new   = base_new_q;
        ea_valid   = valid_q;
        wb_en      = wb_q;
        trap       = trap_q;
        trap_cause = cause_q;
    end

    // A trap belongs to exactly one sampled request.
    p_trap_has_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(req_valid));

    // A trap never coincides with a valid address or a write-back.
    p_trap_blocks_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!wb_en && !ea_valid));

    // A valid word address is always even.
    p_word_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && word_q) |-> !ea[0]);

    // No result flags after an idle edge.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!ea_valid && !wb_en && !trap));

    // A trap always reports at least one cause.
    p_cause_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (trap_cause != '0));

endmodule

// File: tb/tb_ria_agu.sv
`timescale 1ns/1ps
module tb_ria_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  req_base = '0;
    logic [3:0]  req_index = '0;
    logic [9:0]  req_lit = '0;
    logic        req_word = 1'b0;
    logic [15:0] ea;
    logic        ea_valid;
    logic [15:0] base_new;
    logic        wb_en;
    logic        trap;
    logic [1:0]  trap_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ria_agu dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .req_valid(req_valid), .req_mode(req_mode),
        .req_base(req_base), .req_index(req_index), .req_lit(req_lit), .req_word(req_word),
        .ea(ea), .ea_valid(ea_valid), .base_new(base_new), .wb_en(wb_en),
        .trap(trap), .trap_cause(trap_cause)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] i, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic readreg(input logic [3:0] i, output logic [15:0] v);
        rd_idx = i;
        #1;
        v = rd_data;
    endtask

    // One request: drive at a falling edge, sampled at the next rising edge,
    // results read at the following falling edge.
    task automatic issue(input int m, input bit w, input logic [3:0] b,
                         input logic [3:0] x, input logic [9:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'(m); req_word = w;
        req_base = b; req_index = x; req_lit = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic string req_of(input int m);
        case (m)
            1, 2:    return "R4";
            3, 4:    return "R5";
            5:       return "R6";
            6:       return "R7";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [6];
        logic [15:0] xs    [6];
        logic [9:0]  lits  [6];
        logic [15:0] v;

        bases = '{16'h0000, 16'h0001, 16'h7FFE, 16'hFFFF, 16'h1235, 16'h0800};
        xs    = '{16'h0002, 16'hFFFF, 16'h8001, 16'h0001, 16'h0010, 16'hF800};
        lits  = '{10'h000, 10'h3FF, 10'h200, 10'h1FF, 10'h001, 10'h155};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "trap", trap, 0);
        chk("R1", "wb_en", wb_en, 0);
        chk("R1", "ea_valid", ea_valid, 0);
        for (int i = 0; i < 16; i++) begin
            readreg(4'(i), v);
            chk("R1", "reg value", v, 0);
        end

        // R10: plain indirection through unwritten W5
        issue(0, 1'b0, 4'd5, 4'd0, 10'd0);
        chk("R10", "trap", trap, 1);
        chk("R10", "cause", trap_cause, 2'b10);
        chk("R11", "ea_valid on trap", ea_valid, 0);
        @(negedge clk);
        chk("R11", "trap pulse ends", trap, 0);
        chk("R12", "idle ea_valid", ea_valid, 0);

        // R11: post-increment through unwritten W5 leaves it untouched
        issue(1, 1'b1, 4'd5, 4'd0, 10'd0);
        chk("R10", "trap post-inc", trap, 1);
        chk("R11", "wb_en on trap", wb_en, 0);
        readreg(4'd5, v);
        chk("R11", "W5 unchanged", v, 0);

        // R10: mode 5 with unwritten index register W9
        wreg(4'd5, 16'h0100);
        issue(5, 1'b0, 4'd5, 4'd9, 10'd0);
        chk("R10", "trap unwritten index", trap, 1);
        chk("R10", "cause unwritten index", trap_cause, 2'b10);
        wreg(4'd9, 16'h0020);
        issue(5, 1'b0, 4'd5, 4'd9, 10'd0);
        chk("R10", "no trap after write", trap, 0);
        chk("R6", "ea after index written", ea, 16'h0120);

        // Sweep over modes, sizes and operand values
        for (int m = 0; m < 8; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [15:0] b, x, e, nb, step;
                    logic [9:0]  l;
                    bit mod, mis;
                    b = bases[k]; x = xs[k]; l = lits[k];
                    step = (w == 1) ? 16'd2 : 16'd1;       // R3
                    mod = 1'b0; nb = b; e = b;
                    case (m)
                        1: begin nb = b + step; mod = 1'b1; end
                        2: begin nb = b - step; mod = 1'b1; end
                        3: begin nb = b + step; e = nb; mod = 1'b1; end
                        4: begin nb = b - step; e = nb; mod = 1'b1; end
                        5: e = b + x;                        // R8 wraps
                        6: e = b + {{6{l[9]}}, l};
                        default: e = b;
                    endcase
                    mis = (w == 1) && e[0];
                    wreg(4'd3, b);
                    wreg(4'd7, x);
                    issue(m, w[0], 4'd3, 4'd7, l);
                    chk("R9", "trap", trap, mis);
                    chk("R9", "cause", trap_cause, {1'b0, mis});
                    chk("R11", "ea_valid", ea_valid, !mis);
                    chk("R11", "wb_en", wb_en, mod && !mis);
                    if (!mis) chk(req_of(m), "ea", ea, e);
                    if (mod && !mis) chk("R3/R8", "base_new", base_new, nb);
                    readreg(4'd3, v);
                    chk(req_of(m), "base reg after", v, (mod && !mis) ? nb : b);
                end
            end
        end

        // R13: external write beats write-back on the same register
        wreg(4'd3, 16'h0040);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'd1; req_word = 1'b1; req_base = 4'd3;
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 16'hABCD;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk("R13", "wb_en", wb_en, 1);
        chk("R13", "ea", ea, 16'h0040);
        readreg(4'd3, v);
        chk("R13", "reg keeps written value", v, 16'hABCD);

        // R12: quiet after idle edges
        @(negedge clk);
        chk("R12", "wb_en idle", wb_en, 0);
        chk("R12", "ea_valid idle", ea_valid, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule